// File: doc/BRIEF.md
# MESIF Snooping Line-State Controller

This block holds the coherence state of a few cache lines for one private cache that sits on a shared snooping bus. It uses five states: Invalid, Shared, Exclusive, Forward and Modified. Processor reads and writes arrive on a request port that uses valid/ready. Snooped bus transactions arrive on a plain port. For each processor request the block picks a bus command (read, read-for-ownership or data-less upgrade) and a new state. For each snooped transaction it drives the wired shared signal and decides whether this cache flushes dirty data or supplies clean data.

The bus is modelled as atomic. The wired shared input is sampled in the same cycle as the processor request it answers. The issued bus command, the new line state and the flush and supply strobes all appear in the cycle after the request or snoop is taken. The Forward state makes exactly one clean sharer answer a read miss, and the newest reader always takes that role. A write to a line held in Shared or Forward broadcasts an upgrade without moving data.

Back-pressure: a snoop always wins. While `snp_valid` is high, `cpu_ready` is low, and a processor request offered in that cycle is not taken. The request must be held until `cpu_ready` is high. `cpu_valid` with `cpu_ready` high takes the request in one cycle. There is no queue.

Top module: `mesif_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and `bus_cmd`, `flush` and `supply` are 0. State codes on `state_vec` (3 bits per line, line i at bits 3i+2:3i) are I=0, S=1, E=2, F=3, M=4. Bus and snoop command codes are none=0, read=1, read-for-ownership=2, upgrade=3.
- R2: A processor read to an Invalid line with `shared_in` low issues a read (code 1) and leaves the line Exclusive.
- R3: A processor read to an Invalid line with `shared_in` high issues a read and leaves the line Forward.
- R4: A processor read to a line in M, E, S or F issues no bus command and leaves the state unchanged.
- R5: A processor write to a line in Exclusive or Modified leaves it Modified and issues no bus command.
- R6: A processor write to a line in Shared or Forward issues an upgrade (code 3) and leaves the line Modified.
- R7: A processor write to an Invalid line issues a read-for-ownership (code 2) and leaves the line Modified.
- R8: A snooped read moves M, E and F to Shared and leaves S and I unchanged. M pulses `flush`, F pulses `supply`, and E and S pulse neither.
- R9: A snooped read-for-ownership or upgrade moves any valid line to Invalid, and `flush` pulses only if the line was Modified.
- R10: `shared_out` is high in the same cycle as `snp_valid` exactly when the snooped line is valid, and it is low otherwise.
- R11: `cpu_ready` is low whenever `snp_valid` is high, and a request offered then changes no state and issues no command.
- R12: An operation on one line never changes the state of another line, and `flush` and `supply` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request offered |
| cpu_ready | output | 1 | Request can be taken this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_line | input | IDXW | Line index of the request |
| shared_in | input | 1 | Wired shared signal from other caches |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command: 1 read, 2 read-for-ownership, 3 upgrade |
| snp_line | input | IDXW | Line index of the snoop |
| shared_out | output | 1 | This cache holds the snooped line |
| bus_cmd | output | 2 | Issued bus command, one cycle after acceptance |
| bus_line | output | IDXW | Line index of the issued command |
| flush | output | 1 | Dirty data written back for the last snoop |
| supply | output | 1 | Clean data supplied from Forward for the last snoop |
| state_vec | output | 3*NUM_LINES | Current state of every line |

## Verification
Directed sequences first walk each line through its own path. One line goes Exclusive to Modified to Shared to Invalid. Another is read with sharing present, so the Forward hand-off and the silent Shared case can be told apart. A third goes from Invalid straight to Modified through a read-for-ownership. Snoops are sent both to valid lines and to Invalid lines, which separates the cases where the shared signal is driven and where it is not. A snoop that collides with a processor request shows whether back-pressure really blocks the request. A long random mix of requests, snoops and shared-input values across all lines is then compared every cycle against a behavioural model. That run exposes any cross-talk between lines and any wrong strobe.

// File: rtl/mesif_pkg.sv
package mesif_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_F = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_UPG  = 2'd3
  } bus_cmd_e;

  localparam int unsigned ST_W = 3;
endpackage

// File: rtl/mesif_cpu_fsm.sv
module mesif_cpu_fsm
  import mesif_pkg::*;
(
  input  line_st_e cur,
  input  logic     wr,
  input  logic     shared_in,
  output line_st_e nxt,
  output bus_cmd_e cmd
);
  always_comb begin
    nxt = cur;
    cmd = CMD_NONE;
    if (wr) begin
      nxt = ST_M;
      unique case (cur)
        ST_I:       cmd = CMD_RDX;
        ST_S, ST_F: cmd = CMD_UPG;
        default:    cmd = CMD_NONE;
      endcase
    end else if (cur == ST_I) begin
      cmd = CMD_RD;
      nxt = shared_in ? ST_F : ST_E;
    end
  end
endmodule

// File: rtl/mesif_snoop_fsm.sv
module mesif_snoop_fsm
  import mesif_pkg::*;
(
  input  line_st_e cur,
  input  bus_cmd_e scmd,
  output line_st_e nxt,
  output logic     do_flush,
  output logic     do_supply
);
  always_comb begin
    nxt       = cur;
    do_flush  = 1'b0;
    do_supply = 1'b0;
    unique case (scmd)
      CMD_RD: begin
        do_flush  = (cur == ST_M);
        do_supply = (cur == ST_F);
        if (cur == ST_M || cur == ST_E || cur == ST_F) nxt = ST_S;
      end
      CMD_RDX, CMD_UPG: begin
        do_flush = (cur == ST_M);
        nxt      = ST_I;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/mesif_state_table.sv
module mesif_state_table
  import mesif_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned IDXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDXW-1:0]             widx,
  input  line_st_e                    wdata,
  input  logic [IDXW-1:0]             ridx_a,
  input  logic [IDXW-1:0]             ridx_b,
  output line_st_e                    rdata_a,
  output line_st_e                    rdata_b,
  output logic [ST_W*NUM_LINES-1:0]   flat
);
  line_st_e st [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                              st[i] <= ST_I;
      else if (we && widx == IDXW'(i))         st[i] <= wdata;
    end
    assign flat[i*ST_W +: ST_W] = st[i];
  end

  assign rdata_a = st[ridx_a];
  assign rdata_b = st[ridx_b];
endmodule

// File: rtl/mesif_line_ctrl.sv
module mesif_line_ctrl
  import mesif_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned IDXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_valid,
  output logic                        cpu_ready,
  input  logic                        cpu_write,
  input  logic [IDXW-1:0]             cpu_line,
  input  logic                        shared_in,
  input  logic                        snp_valid,
  input  logic [1:0]                  snp_cmd,
  input  logic [IDXW-1:0]             snp_line,
  output logic                        shared_out,
  output logic [1:0]                  bus_cmd,
  output logic [IDXW-1:0]             bus_line,
  output logic                        flush,
  output logic                        supply,
  output logic [ST_W*NUM_LINES-1:0]   state_vec
);
  line_st_e cpu_cur, snp_cur, cpu_nxt, snp_nxt, wdata;
  bus_cmd_e cpu_cmd;
  logic     snp_fl, snp_sp, cpu_take, we;
  logic [IDXW-1:0] widx;

  mesif_state_table #(.NUM_LINES(NUM_LINES)) u_table (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata),
    .ridx_a(cpu_line), .ridx_b(snp_line),
    .rdata_a(cpu_cur), .rdata_b(snp_cur), .flat(state_vec)
  );

  mesif_cpu_fsm u_cpu (
    .cur(cpu_cur), .wr(cpu_write), .shared_in(shared_in),
    .nxt(cpu_nxt), .cmd(cpu_cmd)
  );

  mesif_snoop_fsm u_snp (
    .cur(snp_cur), .scmd(bus_cmd_e'(snp_cmd)),
    .nxt(snp_nxt), .do_flush(snp_fl), .do_supply(snp_sp)
  );

  assign cpu_ready  = !snp_valid;
  assign cpu_take   = cpu_valid && !snp_valid;
  assign shared_out = snp_valid && (snp_cur != ST_I);
  assign we         = snp_valid || cpu_take;
  assign widx       = snp_valid ? snp_line : cpu_line;
  assign wdata      = snp_valid ? snp_nxt  : cpu_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_cmd  <= CMD_NONE;
      bus_line <= '0;
      flush    <= 1'b0;
      supply   <= 1'b0;
    end else begin
      bus_cmd <= cpu_take ? cpu_cmd : CMD_NONE;
      if (cpu_take && cpu_cmd != CMD_NONE) bus_line <= cpu_line;
      flush   <= snp_valid && snp_fl;
      supply  <= snp_valid && snp_sp;
    end
  end
endmodule

// File: rtl/mesif_line_ctrl_chk.sv
module mesif_line_ctrl_chk #(
  parameter int unsigned IDXW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_valid,
  input logic            cpu_ready,
  input logic            cpu_write,
  input logic            snp_valid,
  input logic [1:0]      snp_cmd,
  input logic            shared_out,
  input logic [1:0]      bus_cmd,
  input logic            flush,
  input logic            supply
);
  a_r11_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);

  a_r11_no_cmd_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && snp_valid) |=> (bus_cmd == 2'd0));

  a_r10_shared_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    shared_out |-> snp_valid);

  a_r8_supply_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> $past(snp_valid && snp_cmd == 2'd1));

  a_r9_flush_from_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(snp_valid));

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush && supply));

  a_r2_read_cmd_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd1) |-> $past(cpu_valid && cpu_ready && !cpu_write));

  a_r6_upg_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd3 || bus_cmd == 2'd2) |-> $past(cpu_valid && cpu_ready && cpu_write));
endmodule

bind mesif_line_ctrl mesif_line_ctrl_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_write(cpu_write), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .shared_out(shared_out), .bus_cmd(bus_cmd), .flush(flush), .supply(supply)
);

// File: tb/tb_mesif_line_ctrl.sv
`timescale 1ns/100ps
module tb_mesif_line_ctrl;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0, shared_in = 0, snp_valid = 0;
  logic [IW-1:0] cpu_line = '0, snp_line = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_ready, shared_out, flush, supply;
  logic [1:0] bus_cmd;
  logic [IW-1:0] bus_line;
  logic [3*N-1:0] state_vec;

  int checks = 0;
  int errors = 0;
  int mst [N];

  always #2.5 clk = ~clk;

  mesif_line_ctrl #(.NUM_LINES(N)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_line(cpu_line), .shared_in(shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_line(snp_line),
    .shared_out(shared_out), .bus_cmd(bus_cmd), .bus_line(bus_line),
    .flush(flush), .supply(supply), .state_vec(state_vec)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int ecmd, input int eline,
                           input int efl, input int esp);
    for (int i = 0; i < N; i++)
      chk(tag, $sformatf("state line %0d", i), int'(state_vec[i*3 +: 3]), mst[i]);
    chk(tag, "bus_cmd", int'(bus_cmd), ecmd);
    if (ecmd != 0) chk(tag, "bus_line", int'(bus_line), eline);
    chk(tag, "flush", int'(flush), efl);
    chk(tag, "supply", int'(supply), esp);
  endtask

  // Starts and ends at a falling edge.
  task automatic step(input logic cv, input logic cw, input int cl, input logic sh,
                      input logic sv, input int sc, input int sl, input string tag);
    int ecmd, eline, efl, esp, cur;
    cpu_valid = cv; cpu_write = cw; cpu_line = IW'(cl); shared_in = sh;
    snp_valid = sv; snp_cmd = 2'(sc); snp_line = IW'(sl);
    #1;
    chk(tag, "cpu_ready", int'(cpu_ready), sv ? 0 : 1);
    chk(tag, "shared_out", int'(shared_out), (sv && mst[sl] != 0) ? 1 : 0);
    ecmd = 0; eline = 0; efl = 0; esp = 0;
    if (sv) begin
      cur = mst[sl];
      if (sc == 1) begin
        efl = (cur == 4); esp = (cur == 3);
        if (cur == 4 || cur == 2 || cur == 3) mst[sl] = 1;
      end else if (sc == 2 || sc == 3) begin
        efl = (cur == 4);
        mst[sl] = 0;
      end
    end else if (cv) begin
      cur = mst[cl]; eline = cl;
      if (cw) begin
        if (cur == 0) ecmd = 2;
        else if (cur == 1 || cur == 3) ecmd = 3;
        mst[cl] = 4;
      end else if (cur == 0) begin
        ecmd = 1;
        mst[cl] = sh ? 3 : 2;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag, ecmd, eline, efl, esp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mst[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1", 0, 0, 0, 0);
    // R2, R4, R5, R8, R6, R9 on line 0
    step(1,0,0,0, 0,0,0, "R2");
    step(1,0,0,1, 0,0,0, "R4");
    step(1,1,0,0, 0,0,0, "R5");
    step(1,1,0,0, 0,0,0, "R5");
    step(0,0,0,0, 1,1,0, "R8");
    step(1,1,0,0, 0,0,0, "R6");
    step(0,0,0,0, 1,2,0, "R9");
    // R3 and Forward hand-off on line 1
    step(1,0,1,1, 0,0,0, "R3");
    step(1,0,1,0, 0,0,0, "R4");
    step(0,0,0,0, 1,1,1, "R8");
    step(0,0,0,0, 1,1,1, "R10");
    step(1,1,1,0, 0,0,0, "R6");
    // line 2 Forward then write
    step(1,0,2,1, 0,0,0, "R3");
    step(1,1,2,0, 0,0,0, "R6");
    // line 3 write from Invalid, then upgrade snoop
    step(1,1,3,0, 0,0,0, "R7");
    step(0,0,0,0, 1,3,3, "R9");
    // snoop on an Invalid line
    step(0,0,0,0, 1,1,0, "R10");
    // Exclusive snooped: no strobes
    step(1,0,0,0, 0,0,0, "R2");
    step(0,0,0,0, 1,1,0, "R8");
    step(0,0,0,0, 1,3,0, "R9");
    // back-pressure: write offered during a snoop to another line
    step(1,1,3,0, 1,1,2, "R11");
    step(1,0,3,1, 1,2,1, "R11");
    step(0,0,0,0, 0,0,0, "R12");
    // random mix
    for (int k = 0; k < 600; k++) begin
      step(1'($urandom_range(0,1)), 1'($urandom_range(0,1)), int'($urandom_range(0,N-1)),
           1'($urandom_range(0,1)), 1'($urandom_range(0,2) == 0),
           int'($urandom_range(1,3)), int'($urandom_range(0,N-1)), "R12");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule